// File: doc/BRIEF.md
# Tent-Map Configurable Two-Input Gate

This block is a two-input logic element whose Boolean function is chosen at run time by a 3-bit code. It does not look the function up in a table. Each input is a fixed-point level with three fractional bits. Logic 0 is exactly zero and logic 1 is 0.25. The gate adds both input levels to an offset chosen by the code, and the sum wraps modulo 1. It then applies a one-step tent map of slope 2, or of slope 1 when a mode input asks for it. It subtracts a threshold, also chosen by the code, and clamps the result at zero.

With the offset and threshold that a code selects, the result is either zero or 0.25. This is the same level the inputs use, so the fixed-point output of one gate can drive an input of another gate directly. A plain logic output is also provided: it is 1 whenever the fixed-point output is nonzero. Both outputs are registered, so a result appears one clock after its inputs.

Top module: `tent_logic_gate`

## Requirements
- R1: While `rst` is high at a rising clock edge, both outputs become zero, whatever the other inputs are.
- R2: Outputs change only at a rising clock edge. They show the result of the inputs present at that edge, which gives one cycle of latency.
- R3: Levels use three fractional bits. Logic 0 is code 0 and logic 1 is code 2 (0.25). With inputs at these two levels, `y_lvl` is always 0 or 2.
- R4: With `slope_one` = 0, select codes 0 to 5 give AND, OR, XOR, NAND, NOR and XNOR of the two inputs, with 0 = AND, 1 = OR, 2 = XOR, 3 = NAND, 4 = NOR and 5 = XNOR.
- R5: With `slope_one` = 1, the tent map has slope 1, and codes 0 to 4 give AND, OR, XOR, NAND and NOR.
- R6: Codes 6 and 7 in either mode, and code 5 with `slope_one` = 1, force `y_lvl` to zero.
- R7: `y_bit` is 1 exactly when `y_lvl` is nonzero.
- R8: The sum of offset and inputs wraps modulo 1, so a sum of 1.0 acts as 0 and 1.25 acts as 0.25. NOR and XNOR with both inputs at 1 depend on this.
- R9: Feeding `y_lvl` of one gate into an input of a second gate gives the composed Boolean function, with one cycle of latency per gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_lvl | input | 3 | First input level, fixed point with three fractional bits |
| b_lvl | input | 3 | Second input level, fixed point with three fractional bits |
| gate_sel | input | 3 | Function select code |
| slope_one | input | 1 | 1 selects the slope-1 map, 0 the slope-2 map |
| y_lvl | output | 3 | Result level, zero or 0.25, for cascading |
| y_bit | output | 1 | Result as a plain logic bit |

## Verification
The level assertion assumes that both input levels are one of the two legal codes, 0 or 2. It checks the output only on cycles where that holds. Other codes are outside the gate's contract, and the output is then allowed to take other fractional values. The stimulus drives only legal levels: it builds inputs from logic bits, and in the cascade test the chained gate's input comes from a real gate output. The latency and stability properties hold only on cycles that follow a cycle without reset, and the bench releases reset before it applies any checked vector.

// File: rtl/tgate_pkg.sv
package tgate_pkg;

    localparam int FRAC_W = 3;
    localparam int SEL_W  = 3;
    localparam int N_IN   = 2;

    typedef logic [FRAC_W-1:0] frac_t;
    typedef logic [FRAC_W:0]   mapv_t;

    localparam frac_t LVL_ONE = frac_t'(1 << (FRAC_W - 2));

    typedef enum logic [SEL_W-1:0] {
        G_AND  = 3'd0,
        G_OR   = 3'd1,
        G_XOR  = 3'd2,
        G_NAND = 3'd3,
        G_NOR  = 3'd4,
        G_XNOR = 3'd5,
        G_RSV6 = 3'd6,
        G_RSV7 = 3'd7
    } gate_sel_e;

    typedef enum logic {
        SLOPE_TWO = 1'b0,
        SLOPE_ONE = 1'b1
    } slope_e;

    typedef struct packed {
        logic  valid;
        frac_t x0;
        frac_t xc;
    } gate_param_t;

    function automatic frac_t eighths(int n);
        return frac_t'(n << (FRAC_W - 3));
    endfunction

    function automatic gate_param_t mk(int x0_8, int xc_8);
        gate_param_t p;
        p.valid = 1'b1;
        p.x0    = eighths(x0_8);
        p.xc    = eighths(xc_8);
        return p;
    endfunction

    function automatic gate_param_t lookup(gate_sel_e s, slope_e m);
        gate_param_t p;
        p = '0;
        if (m == SLOPE_TWO) begin
            case (s)
                G_AND:   p = mk(0, 6);
                G_OR:    p = mk(1, 4);
                G_XOR:   p = mk(2, 6);
                G_NAND:  p = mk(3, 4);
                G_NOR:   p = mk(4, 6);
                G_XNOR:  p = mk(6, 2);
                default: p = '0;
            endcase
        end else begin
            case (s)
                G_AND:   p = mk(0, 2);
                G_OR:    p = mk(1, 1);
                G_XOR:   p = mk(2, 2);
                G_NAND:  p = mk(3, 1);
                G_NOR:   p = mk(4, 2);
                default: p = '0;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/tg_param_sel.sv
module tg_param_sel
    import tgate_pkg::*;
(
    input  gate_sel_e   sel,
    input  slope_e      slope,
    output gate_param_t prm
);

    always_comb begin
        prm = lookup(sel, slope);
    end

endmodule

// File: rtl/tg_wrap_accum.sv
module tg_wrap_accum
    import tgate_pkg::*;
#(
    parameter int NI = N_IN
) (
    input  frac_t                    x0,
    input  logic [NI-1:0][FRAC_W-1:0] lvl,
    output frac_t                    acc
);

    always_comb begin
        acc = x0;
        for (int i = 0; i < NI; i++) begin
            acc = acc + lvl[i];
        end
    end

endmodule

// File: rtl/tg_tent_map.sv
module tg_tent_map
    import tgate_pkg::*;
(
    input  frac_t  x,
    input  slope_e slope,
    output mapv_t  y
);

    localparam mapv_t UNIT = mapv_t'(1 << FRAC_W);

    mapv_t xe;
    mapv_t mirror;
    mapv_t low;

    always_comb begin
        xe     = {1'b0, x};
        mirror = UNIT - xe;
        low    = (xe < mirror) ? xe : mirror;
        y      = (slope == SLOPE_TWO) ? mapv_t'(low << 1) : low;
    end

endmodule

// File: rtl/tg_clamp.sv
module tg_clamp
    import tgate_pkg::*;
(
    input  mapv_t v,
    input  frac_t xc,
    input  logic  en,
    output frac_t y
);

    mapv_t xce;
    mapv_t diff;

    always_comb begin
        xce  = {1'b0, xc};
        diff = v - xce;
        if (en && (v > xce)) begin
            y = diff[FRAC_W] ? '1 : diff[FRAC_W-1:0];
        end else begin
            y = '0;
        end
    end

endmodule

// File: rtl/tent_logic_gate.sv
module tent_logic_gate
    import tgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] a_lvl,
    input  logic [2:0] b_lvl,
    input  logic [2:0] gate_sel,
    input  logic       slope_one,
    output logic [2:0] y_lvl,
    output logic       y_bit
);

    gate_sel_e                    sel_e;
    slope_e                       slope_e_s;
    gate_param_t                  prm;
    logic [N_IN-1:0][FRAC_W-1:0]  ins;
    frac_t                        acc;
    mapv_t                        mapped;
    frac_t                        nxt;

    assign sel_e     = gate_sel_e'(gate_sel);
    assign slope_e_s = slope_e'(slope_one);
    assign ins[0]    = a_lvl;
    assign ins[1]    = b_lvl;

    tg_param_sel u_prm (
        .sel   (sel_e),
        .slope (slope_e_s),
        .prm   (prm)
    );

    tg_wrap_accum #(.NI(N_IN)) u_acc (
        .x0  (prm.x0),
        .lvl (ins),
        .acc (acc)
    );

    tg_tent_map u_map (
        .x     (acc),
        .slope (slope_e_s),
        .y     (mapped)
    );

    tg_clamp u_clamp (
        .v  (mapped),
        .xc (prm.xc),
        .en (prm.valid),
        .y  (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            y_lvl <= '0;
            y_bit <= 1'b0;
        end else begin
            y_lvl <= nxt;
            y_bit <= |nxt;
        end
    end

endmodule

module tent_logic_gate_chk
    import tgate_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] a_lvl,
    input logic [2:0] b_lvl,
    input logic [2:0] gate_sel,
    input logic       slope_one,
    input logic [2:0] y_lvl,
    input logic       y_bit
);

    logic legal_in;
    assign legal_in = ((a_lvl == 3'd0) || (a_lvl == LVL_ONE)) &&
                      ((b_lvl == 3'd0) || (b_lvl == LVL_ONE));

    // R3: legal inputs give only the two legal output levels
    assert_level_R3: assert property (@(posedge clk) disable iff (rst)
        legal_in |=> ((y_lvl == 3'd0) || (y_lvl == LVL_ONE)));

    // R7: logic bit agrees with the level
    assert_bit_R7: assert property (@(posedge clk) disable iff (rst)
        y_bit == (y_lvl != 3'd0));

    // R6: reserved codes and slope-1 code 5 give zero
    assert_reserved_R6: assert property (@(posedge clk) disable iff (rst)
        ((gate_sel >= 3'd6) || (slope_one && gate_sel == 3'd5)) |=> (y_lvl == 3'd0));

    // R4: AND with any zero input gives zero
    assert_and_zero_R4: assert property (@(posedge clk) disable iff (rst)
        ((gate_sel == 3'd0) && ((a_lvl == 3'd0) || (b_lvl == 3'd0))) |=> (y_lvl == 3'd0));

    // R2: inputs held over two edges leave the output unchanged
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(a_lvl) && $stable(b_lvl) && $stable(gate_sel)
         && $stable(slope_one)) |=> $stable(y_lvl));

endmodule

bind tent_logic_gate tent_logic_gate_chk u_chk (.*);

// File: tb/tb_tent_logic_gate.sv
`timescale 1ns/1ps
module tb_tent_logic_gate;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] a_lvl = '0, b_lvl = '0, gate_sel = '0;
    logic       slope_one = 1'b0;
    logic [2:0] y_lvl;
    logic       y_bit;

    logic [2:0] c_b_lvl = '0, c_sel = '0;
    logic [2:0] c_y_lvl;
    logic       c_y_bit;

    localparam logic [2:0] ONE = 3'd2;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } item_t;
    item_t q[$];

    always #2.5 clk = ~clk;

    tent_logic_gate dut (
        .clk(clk), .rst(rst), .a_lvl(a_lvl), .b_lvl(b_lvl),
        .gate_sel(gate_sel), .slope_one(slope_one),
        .y_lvl(y_lvl), .y_bit(y_bit)
    );

    tent_logic_gate dut_c (
        .clk(clk), .rst(rst), .a_lvl(y_lvl), .b_lvl(c_b_lvl),
        .gate_sel(c_sel), .slope_one(1'b0),
        .y_lvl(c_y_lvl), .y_bit(c_y_bit)
    );

    function automatic logic ref_bit(logic m, int s, logic a, logic b);
        case (s)
            0: return a & b;
            1: return a | b;
            2: return a ^ b;
            3: return ~(a & b);
            4: return ~(a | b);
            5: return m ? 1'b0 : ~(a ^ b);
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(logic m, int s, logic a, logic b, string tag);
        item_t it;
        @(negedge clk);
        slope_one = m;
        gate_sel  = 3'(s);
        a_lvl     = a ? ONE : 3'd0;
        b_lvl     = b ? ONE : 3'd0;
        it.exp = ref_bit(m, s, a, b) ? ONE : 3'd0;
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(y_lvl == it.exp, {it.tag, " R3 level"}, y_lvl, it.exp);
                check(y_bit == (it.exp != 0), "R7 logic bit", y_bit, it.exp != 0);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset with inputs that would otherwise give logic 1 (NOR of zeros)
        gate_sel = 3'd4;
        repeat (3) @(posedge clk);
        #1;
        check(y_lvl == 0, "R1 reset level", y_lvl, 0);
        check(y_bit == 0, "R1 reset bit", y_bit, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2: output holds until the next rising edge
        drive(1'b0, 2, 1'b0, 1'b0, "R2 xor00");
        @(posedge clk); #1;
        @(negedge clk);
        a_lvl = ONE;
        #1;
        check(y_lvl == 0, "R2 no early change", y_lvl, 0);
        @(posedge clk); #1;
        check(y_lvl == ONE, "R2 updated after edge", y_lvl, ONE);

        // R4 / R8: slope-2 truth tables; R5 / R6: slope-1 and reserved codes
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 8; s++) begin
                for (int v = 0; v < 4; v++) begin
                    drive(m[0], s, v[1], v[0],
                          (s >= 6 || (m == 1 && s == 5)) ? "R6" :
                          (m == 0) ? ((v == 3 && s >= 4) ? "R4 R8" : "R4") : "R5");
                end
            end
        end
        // R3: alternating pattern, back-to-back changes
        drive(1'b0, 5, 1'b1, 1'b1, "R8 xnor11");
        drive(1'b0, 4, 1'b1, 1'b1, "R8 nor11");
        drive(1'b1, 3, 1'b1, 1'b1, "R5 nand11");
        drive(1'b0, 1, 1'b0, 1'b0, "R4 or00");
        drive(1'b1, 1, 1'b1, 1'b0, "R5 or10");
        @(posedge clk); #1;
        @(posedge clk); #1;

        // R9: cascade, first gate AND then second gate XOR with 1 gives NAND
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            slope_one = 1'b0;
            gate_sel  = 3'd0;
            a_lvl     = v[1] ? ONE : 3'd0;
            b_lvl     = v[0] ? ONE : 3'd0;
            c_sel     = 3'd2;
            c_b_lvl   = ONE;
            @(posedge clk); @(posedge clk); #1;
            check(c_y_lvl == (((v[1] & v[0]) == 1'b0) ? ONE : 3'd0),
                  "R9 cascade nand", c_y_lvl, ((v[1] & v[0]) == 1'b0) ? ONE : 0);
        end
        // R9: OR into XNOR with 0 gives NOR
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            gate_sel  = 3'd1;
            a_lvl     = v[1] ? ONE : 3'd0;
            b_lvl     = v[0] ? ONE : 3'd0;
            c_sel     = 3'd5;
            c_b_lvl   = 3'd0;
            @(posedge clk); @(posedge clk); #1;
            check(c_y_lvl == (((v[1] | v[0]) == 1'b0) ? ONE : 3'd0),
                  "R9 cascade nor", c_y_lvl, ((v[1] | v[0]) == 1'b0) ? ONE : 0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule